// File: doc/BRIEF.md
# Spanning Tree Port State Filter

This block holds a 2-bit spanning tree state for each port of a small three-port switch. It turns that state into per-frame decisions. When the receive side presents a frame, the block answers whether the frame is accepted. When the transmit side presents a frame queued to a port, the block answers whether the frame may leave. Each receive request carries an override flag, which is set when the matched address entry is both static and marked for override. Each transmit request carries the override that a host-issued frame sets. With these flags, control and host traffic can pass a port that is not forwarding. The block also drives one enable per port that allows source-address learning.

Each port has its own small state machine with three named states. `ST_BLOCK` covers both the blocking and listening codes (01), and also the unused code 11. `ST_LEARN` is code 10. `ST_FWD` is code 00. The only transitions are configuration writes, and each one is named after its target state. `go_block` is a write of 01 or 11. `go_learn` is a write of 10. `go_fwd` is a write of 00. Any state may go to any state. Reset places every port in `ST_BLOCK`. The decision for each request is registered once, and it comes out with a valid strobe one cycle after the request.

Top module: `stp_port_filter`

## Requirements
- R1: After reset every port is in ST_BLOCK, `learn_en` is all zeros, and `rx_vld` and `tx_vld` are low.
- R2: A write with `cfg_we` high stores the state for port `cfg_port` from `cfg_state`: 2'b00 gives ST_FWD, 2'b01 gives ST_BLOCK, 2'b10 gives ST_LEARN, and 2'b11 gives ST_BLOCK.
- R3: In ST_BLOCK, a receive request is accepted only when `rx_ovr` is 1. A transmit request is permitted only when `tx_ovr` is 1. `learn_en` for the port is 0.
- R4: In ST_LEARN, receive and transmit requests pass only with their override bit set, and `learn_en` for the port is 1.
- R5: In ST_FWD, receive and transmit requests always pass, whatever the override bit, and `learn_en` for the port is 1.
- R6: `rx_vld` (`tx_vld`) is high exactly in the cycle after `rx_req` (`tx_req`) was sampled high. `rx_accept` (`tx_permit`) is 0 whenever its valid is low.
- R7: A request sampled in the same cycle as a state write to the same port is decided with the state held before that write. `learn_en` shows the new state starting in the cycle after the write.
- R8: A port index of NPORTS or higher (3 with the defaults) is out of range. A write to it changes no port's state, and a request to it returns a valid decision of 0 even when the override bit is set.
- R9: Receive and transmit requests may arrive in the same cycle, for the same port or for different ports, and each is decided independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | State write strobe |
| cfg_port | input | 2 | Port index for the state write |
| cfg_state | input | 2 | New state code |
| rx_req | input | 1 | Receive decision request |
| rx_port | input | 2 | Ingress port of the frame |
| rx_ovr | input | 1 | Lookup result is static and override |
| tx_req | input | 1 | Transmit decision request |
| tx_port | input | 2 | Egress port of the frame |
| tx_ovr | input | 1 | Host frame carries the spanning tree override |
| rx_vld | output | 1 | Receive decision valid |
| rx_accept | output | 1 | Frame accepted |
| tx_vld | output | 1 | Transmit decision valid |
| tx_permit | output | 1 | Frame may be transmitted |
| learn_en | output | 3 | Per-port source-address learning enable |

## Verification
A receive or transmit decision is due one clock edge after its request. That is the edge that loads the result register, and the valid strobe rises in the same cycle. `learn_en` is due at the edge that performs the state write, because it is decoded from the state register with no further register. The bench drives every input on a falling edge. It then samples 2 ns after the next rising edge and compares against a model state array. Before it compares, it computes the expected decision from the model as it stood before that cycle's write. It then applies the write to the model and compares `learn_en` against the updated model.

// File: rtl/stp_pkg.sv
package stp_pkg;
    typedef enum logic [1:0] {
        ST_FWD   = 2'b00,
        ST_BLOCK = 2'b01,
        ST_LEARN = 2'b10
    } stp_state_e;
endpackage

// File: rtl/stp_port_fsm.sv
module stp_port_fsm
    import stp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_code,
    output stp_state_e state,
    output logic       learn
);
    stp_state_e st_q, st_d;

    // Next state: any state reaches any state through a write
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_code)
                2'b00:   st_d = ST_FWD;     // go_fwd
                2'b10:   st_d = ST_LEARN;   // go_learn
                2'b01:   st_d = ST_BLOCK;   // go_block
                default: st_d = ST_BLOCK;   // go_block (unused code 11)
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_BLOCK;
        else        st_q <= st_d;
    end

    // Outputs of the state machine
    always_comb begin
        unique case (st_q)
            ST_FWD:   learn = 1'b1;
            ST_LEARN: learn = 1'b1;
            default:  learn = 1'b0;
        endcase
    end

    assign state = st_q;

    // R2: a write of code 11 must leave the port blocking
    a_r2_code11_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code == 2'b11) |=> (state == ST_BLOCK && !learn));
    // R2: a write of 00 must reach forwarding
    a_r2_code00_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code == 2'b00) |=> (state == ST_FWD));
    // R7: without a write the state holds
    a_r7_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state));
endmodule

// File: rtl/stp_gate.sv
module stp_gate
    import stp_pkg::*;
(
    input  stp_state_e state,
    input  logic       ovr,
    output logic       pass
);
    always_comb begin
        unique case (state)
            ST_FWD:   pass = 1'b1;
            ST_LEARN: pass = ovr;
            default:  pass = ovr;
        endcase
    end
endmodule

// File: rtl/stp_port_filter.sv
module stp_port_filter
    import stp_pkg::*;
#(
    parameter int NPORTS = 3,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS + 1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PW-1:0]     cfg_port,
    input  logic [1:0]        cfg_state,
    input  logic              rx_req,
    input  logic [PW-1:0]     rx_port,
    input  logic              rx_ovr,
    input  logic              tx_req,
    input  logic [PW-1:0]     tx_port,
    input  logic              tx_ovr,
    output logic              rx_vld,
    output logic              rx_accept,
    output logic              tx_vld,
    output logic              tx_permit,
    output logic [NPORTS-1:0] learn_en
);
    stp_state_e port_st [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        stp_port_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && cfg_port == PW'(p)),
            .wr_code (cfg_state),
            .state   (port_st[p]),
            .learn   (learn_en[p])
        );
    end

    stp_state_e rx_st, tx_st;
    logic       rx_in_range, tx_in_range;

    always_comb begin
        rx_st = ST_BLOCK;
        tx_st = ST_BLOCK;
        rx_in_range = 1'b0;
        tx_in_range = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (rx_port == PW'(i)) begin
                rx_st = port_st[i];
                rx_in_range = 1'b1;
            end
            if (tx_port == PW'(i)) begin
                tx_st = port_st[i];
                tx_in_range = 1'b1;
            end
        end
    end

    logic rx_pass, tx_pass;

    stp_gate u_rx_gate (.state(rx_st), .ovr(rx_ovr), .pass(rx_pass));
    stp_gate u_tx_gate (.state(tx_st), .ovr(tx_ovr), .pass(tx_pass));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_vld    <= 1'b0;
            rx_accept <= 1'b0;
            tx_vld    <= 1'b0;
            tx_permit <= 1'b0;
        end else begin
            rx_vld    <= rx_req;
            rx_accept <= rx_req && rx_in_range && rx_pass;
            tx_vld    <= tx_req;
            tx_permit <= tx_req && tx_in_range && tx_pass;
        end
    end

    // R6: valid follows the request by one cycle
    a_r6_rx_vld: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req |=> rx_vld);
    a_r6_tx_vld: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_vld);
    // R6: no decision without valid
    a_r6_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_vld |-> !rx_accept);
    a_r6_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_vld |-> !tx_permit);
    // R5: forwarding ports always pass
    a_r5_rx_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && rx_in_range && rx_st == ST_FWD) |=> rx_accept);
    // R3/R4: a non-forwarding port without override never passes
    a_r3_tx_block: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ovr && tx_st != ST_FWD) |=> !tx_permit);
    // R8: out-of-range requests are denied
    a_r8_rx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_req && !rx_in_range) |=> (rx_vld && !rx_accept));
endmodule

// File: tb/test_stp_port_filter.sv
module test_stp_port_filter;
    localparam int NP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_port = '0, cfg_state = '0;
    logic       rx_req = 1'b0, rx_ovr = 1'b0, tx_req = 1'b0, tx_ovr = 1'b0;
    logic [1:0] rx_port = '0, tx_port = '0;
    logic       rx_vld, rx_accept, tx_vld, tx_permit;
    logic [NP-1:0] learn_en;

    int checks = 0;
    int errors = 0;
    logic [1:0] model [NP];

    always #5 clk = ~clk;

    stp_port_filter i_stp_port_filter (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_state(cfg_state),
        .rx_req(rx_req), .rx_port(rx_port), .rx_ovr(rx_ovr),
        .tx_req(tx_req), .tx_port(tx_port), .tx_ovr(tx_ovr),
        .rx_vld(rx_vld), .rx_accept(rx_accept),
        .tx_vld(tx_vld), .tx_permit(tx_permit),
        .learn_en(learn_en)
    );

    // Expected pass: 00 forwards, any other stored code needs the override
    function automatic logic exp_pass(input logic [1:0] port, input logic ovr);
        if (port >= 2'(NP)) return 1'b0;
        if (model[port] == 2'b00) return 1'b1;
        return ovr;
    endfunction

    function automatic logic [NP-1:0] exp_learn();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = (model[i] != 2'b01);
        return v;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check 2 ns after the rising edge
    task automatic step(input logic we, input logic [1:0] wp, input logic [1:0] ws,
                        input logic rq, input logic [1:0] rp, input logic ro,
                        input logic tq, input logic [1:0] tp, input logic to,
                        input string req);
        logic erx, etx;
        @(negedge clk);
        cfg_we = we; cfg_port = wp; cfg_state = ws;
        rx_req = rq; rx_port = rp; rx_ovr = ro;
        tx_req = tq; tx_port = tp; tx_ovr = to;
        erx = rq && exp_pass(rp, ro);   // R7: decided on pre-write state
        etx = tq && exp_pass(tp, to);
        if (we && wp < 2'(NP)) model[wp] = (ws == 2'b11) ? 2'b01 : ws;
        @(posedge clk);
        #2;
        check({req, " R6 rx_vld"}, 8'(rx_vld), 8'(rq));
        check({req, " R6 tx_vld"}, 8'(tx_vld), 8'(tq));
        check({req, " rx_accept"}, 8'(rx_accept), 8'(erx));
        check({req, " tx_permit"}, 8'(tx_permit), 8'(etx));
        check({req, " learn_en"}, 8'(learn_en), 8'(exp_learn()));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NP; i++) model[i] = 2'b01;
        repeat (3) @(posedge clk);
        #2;
        check("R1 learn_en", 8'(learn_en), 8'h00);
        check("R1 rx_vld", 8'(rx_vld), 8'h0);
        check("R1 tx_vld", 8'(tx_vld), 8'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: blocking after reset, with and without override
        step(0, 0, 0, 1, 0, 0, 1, 1, 0, "R3 block no ovr");
        step(0, 0, 0, 1, 2, 1, 1, 2, 1, "R3 block ovr");
        // R2/R4: learning
        step(1, 1, 2'b10, 0, 0, 0, 0, 0, 0, "R2 write learn");
        step(0, 0, 0, 1, 1, 0, 1, 1, 1, "R4 learn");
        // R2/R5: forwarding ignores override
        step(1, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R2 write fwd");
        step(0, 0, 0, 1, 0, 0, 1, 0, 0, "R5 fwd");
        // R7: write to same port as request in same cycle
        step(1, 0, 2'b01, 1, 0, 0, 1, 0, 0, "R7 fwd->block same cycle");
        step(0, 0, 0, 1, 0, 0, 1, 0, 0, "R7 after write");
        // R2: code 11 becomes blocking
        step(1, 1, 2'b11, 1, 1, 0, 0, 0, 0, "R2 code11");
        step(0, 0, 0, 1, 1, 0, 1, 1, 0, "R2 code11 decision");
        // R8: out-of-range port
        step(1, 3, 2'b00, 1, 3, 1, 1, 3, 1, "R8 out of range");
        // R9: concurrent on different ports
        step(1, 2, 2'b00, 0, 0, 0, 0, 0, 0, "R9 setup");
        step(0, 0, 0, 1, 2, 0, 1, 0, 0, "R9 concurrent");

        // Random mix covering R2..R9
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[0] & r[1], r[3:2], r[5:4], r[6], r[8:7], r[9],
                 r[10], r[12:11], r[13], "R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule